// File: doc/BRIEF.md
# Signature Store Snooper and Message Decoder

This block sits beside a 32-bit data-memory write bus and watches it without driving anything back. A program running on a processor under test reports to its environment by storing words to one reserved address. The block picks out the full-word stores to that address and decodes them as short framed messages. The low byte of a header word names the message kind. A short message carries its value in the upper 24 bits of the header. A longer message is followed by a fixed number of data words sent to the same address.

Each decoded result leaves the block on its own port group with a one-cycle valid pulse. These results are a core status code, a test verdict, a register-file dump delivered one indexed word at a time, and a control-register address/value pair. Every output is registered, so results appear one clock after the qualifying store is sampled.

Top module: `sig_snoop`

## Requirements
- R1: After reset every valid pulse, the dump-complete pulse and the protocol-error flag are low.
- R2: A cycle counts as a store only when write enable is high, all four byte strobes are set and the address equals SIG_ADDR (default 0x8FFFFFFC). Any other cycle produces no output and leaves decoding state unchanged, including the position inside a pending burst.
- R3: A header whose low byte is 0x00 (status kind) pulses status_valid for one cycle, on the clock after the store is sampled, with status_code equal to header bits [31:8].
- R4: A header whose low byte is 0x01 (verdict kind) pulses result_valid for one cycle, one clock after the store, with result_code equal to header bits [31:8] (0 means pass).
- R5: A header whose low byte is 0x02 (register dump) makes the next 32 stores data. Each one pulses gpr_valid one clock later, with gpr_data equal to the stored word and gpr_idx counting 0 up to 31.
- R6: While a dump or control-register burst is pending, every store is taken as data whatever its low byte holds, and no header is decoded.
- R7: gpr_done pulses for one cycle on the clock after the pulse that carries index 31.
- R8: A header whose low byte is 0x03 latches header bits [19:8] as the control-register address. The next store pulses csr_valid one clock later with csr_addr and csr_data (the stored word) presented together.
- R9: A header with any other low-byte value produces no output pulse and leaves the decoder idle. It sets proto_err, which stays set until reset.
- R10: At most one of status_valid, result_valid, gpr_valid and csr_valid is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 32 | Snooped write address |
| bus_wdata | input | 32 | Snooped write data |
| bus_we | input | 1 | Snooped write enable |
| bus_be | input | 4 | Snooped byte strobes |
| status_valid | output | 1 | Status message pulse |
| status_code | output | 24 | Status value |
| result_valid | output | 1 | Verdict message pulse |
| result_code | output | 24 | Verdict value |
| gpr_valid | output | 1 | Dump word pulse |
| gpr_idx | output | 5 | Register index of the dump word |
| gpr_data | output | 32 | Dump word value |
| gpr_done | output | 1 | Pulse after the last dump word |
| csr_valid | output | 1 | Control-register pair pulse |
| csr_addr | output | 12 | Control-register address |
| csr_data | output | 32 | Control-register value |
| proto_err | output | 1 | Sticky unknown-kind flag |

## Verification
The assertions assume that the bus inputs hold known values at every rising edge and that each cycle with a qualifying write is exactly one store, so a store held for two cycles would be counted twice. The stimulus changes the bus only on falling edges and drops write enable after one cycle for every store. It also puts non-qualifying cycles between headers and inside bursts, so that R2 is tested against pending state.

// File: rtl/sig_snoop_pkg.sv
package sig_snoop_pkg;
  localparam int WORD_W = 32;
  localparam int KIND_W = 8;
  localparam int PAY_W  = WORD_W - KIND_W;

  typedef enum logic [KIND_W-1:0] {
    MK_STATUS = 8'h00,
    MK_RESULT = 8'h01,
    MK_DUMP   = 8'h02,
    MK_CREG   = 8'h03
  } msg_kind_e;

  typedef enum logic [1:0] {ST_HDR, ST_DUMP, ST_CREG} dec_state_e;

  function automatic logic [KIND_W-1:0] hdr_kind(input logic [WORD_W-1:0] w);
    return w[KIND_W-1:0];
  endfunction

  function automatic logic [PAY_W-1:0] hdr_payload(input logic [WORD_W-1:0] w);
    return w[WORD_W-1:KIND_W];
  endfunction
endpackage

// File: rtl/sig_snoop_match.sv
module sig_snoop_match #(
  parameter logic [31:0] SIG_ADDR = 32'h8FFF_FFFC,
  parameter int          BE_W     = 4
) (
  input  logic [31:0]     bus_addr,
  input  logic            bus_we,
  input  logic [BE_W-1:0] bus_be,
  output logic            word_hit
);
  always_comb word_hit = bus_we && (&bus_be) && (bus_addr == SIG_ADDR);
endmodule

// File: rtl/sig_snoop_dec.sv
module sig_snoop_dec
  import sig_snoop_pkg::*;
#(
  parameter int NGPR  = 32,
  parameter int CSR_W = 12,
  localparam int CW   = $clog2(NGPR + 1),
  localparam int IW   = $clog2(NGPR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_hit,
  input  logic [WORD_W-1:0] word,
  output logic              status_valid,
  output logic [PAY_W-1:0]  status_code,
  output logic              result_valid,
  output logic [PAY_W-1:0]  result_code,
  output logic              gpr_valid,
  output logic [IW-1:0]     gpr_idx,
  output logic [WORD_W-1:0] gpr_data,
  output logic              gpr_done,
  output logic              csr_valid,
  output logic [CSR_W-1:0]  csr_addr,
  output logic [WORD_W-1:0] csr_data,
  output logic              proto_err
);
  dec_state_e    state;
  logic [CW-1:0] remain;
  logic          last_dump_word;

  always_comb last_dump_word = gpr_valid && (gpr_idx == IW'(NGPR - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_HDR;
      remain       <= '0;
      status_valid <= 1'b0;
      status_code  <= '0;
      result_valid <= 1'b0;
      result_code  <= '0;
      gpr_valid    <= 1'b0;
      gpr_idx      <= '0;
      gpr_data     <= '0;
      gpr_done     <= 1'b0;
      csr_valid    <= 1'b0;
      csr_addr     <= '0;
      csr_data     <= '0;
      proto_err    <= 1'b0;
    end else begin
      status_valid <= 1'b0;
      result_valid <= 1'b0;
      gpr_valid    <= 1'b0;
      csr_valid    <= 1'b0;
      gpr_done     <= last_dump_word;
      if (word_hit) begin
        unique case (state)
          ST_HDR: begin
            case (hdr_kind(word))
              MK_STATUS: begin
                status_valid <= 1'b1;
                status_code  <= hdr_payload(word);
              end
              MK_RESULT: begin
                result_valid <= 1'b1;
                result_code  <= hdr_payload(word);
              end
              MK_DUMP: begin
                state  <= ST_DUMP;
                remain <= CW'(NGPR);
              end
              MK_CREG: begin
                state    <= ST_CREG;
                csr_addr <= word[KIND_W +: CSR_W];
              end
              default: proto_err <= 1'b1;
            endcase
          end
          ST_DUMP: begin
            gpr_valid <= 1'b1;
            gpr_idx   <= IW'(NGPR - int'(remain));
            gpr_data  <= word;
            remain    <= remain - 1'b1;
            if (remain == CW'(1)) state <= ST_HDR;
          end
          ST_CREG: begin
            csr_valid <= 1'b1;
            csr_data  <= word;
            state     <= ST_HDR;
          end
          default: state <= ST_HDR;
        endcase
      end
    end
  end

  a_r10_one_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({status_valid, result_valid, gpr_valid, csr_valid}));

  a_r2_no_store_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !word_hit |=> !(status_valid || result_valid || gpr_valid || csr_valid));

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    gpr_done |-> ($past(gpr_valid) && $past(gpr_idx) == IW'(NGPR - 1)));

  a_r8_pair_from_store: assert property (@(posedge clk) disable iff (!rst_n)
    csr_valid |-> $past(word_hit));

  a_r5_dump_from_store: assert property (@(posedge clk) disable iff (!rst_n)
    gpr_valid |-> $past(word_hit));
endmodule

// File: rtl/sig_snoop.sv
module sig_snoop
  import sig_snoop_pkg::*;
#(
  parameter logic [31:0] SIG_ADDR = 32'h8FFF_FFFC,
  parameter int          NGPR     = 32,
  parameter int          CSR_W    = 12,
  localparam int         IW       = $clog2(NGPR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  input  logic [3:0]        bus_be,
  output logic              status_valid,
  output logic [23:0]       status_code,
  output logic              result_valid,
  output logic [23:0]       result_code,
  output logic              gpr_valid,
  output logic [IW-1:0]     gpr_idx,
  output logic [31:0]       gpr_data,
  output logic              gpr_done,
  output logic              csr_valid,
  output logic [CSR_W-1:0]  csr_addr,
  output logic [31:0]       csr_data,
  output logic              proto_err
);
  logic word_hit;

  sig_snoop_match #(.SIG_ADDR(SIG_ADDR), .BE_W(4)) u_match (
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_be   (bus_be),
    .word_hit (word_hit)
  );

  sig_snoop_dec #(.NGPR(NGPR), .CSR_W(CSR_W)) u_dec (
    .clk          (clk),
    .rst_n        (rst_n),
    .word_hit     (word_hit),
    .word         (bus_wdata),
    .status_valid (status_valid),
    .status_code  (status_code),
    .result_valid (result_valid),
    .result_code  (result_code),
    .gpr_valid    (gpr_valid),
    .gpr_idx      (gpr_idx),
    .gpr_data     (gpr_data),
    .gpr_done     (gpr_done),
    .csr_valid    (csr_valid),
    .csr_addr     (csr_addr),
    .csr_data     (csr_data),
    .proto_err    (proto_err)
  );
endmodule

// File: tb/tb_sig_snoop.sv
`timescale 1ns/1ps
module tb_sig_snoop;
  localparam logic [31:0] SA = 32'h8FFF_FFFC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_be = '0;
  logic        status_valid, result_valid, gpr_valid, gpr_done, csr_valid, proto_err;
  logic [23:0] status_code, result_code;
  logic [4:0]  gpr_idx;
  logic [31:0] gpr_data, csr_data;
  logic [11:0] csr_addr;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sig_snoop dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_be(bus_be),
    .status_valid(status_valid), .status_code(status_code),
    .result_valid(result_valid), .result_code(result_code),
    .gpr_valid(gpr_valid), .gpr_idx(gpr_idx), .gpr_data(gpr_data),
    .gpr_done(gpr_done), .csr_valid(csr_valid), .csr_addr(csr_addr),
    .csr_data(csr_data), .proto_err(proto_err)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulses(input logic [3:0] exp, input string req);
    logic [3:0] act;
    act = {status_valid, result_valid, gpr_valid, csr_valid};
    chk(act === exp, req, 64'(act), 64'(exp));
  endtask

  // drive one bus cycle from a falling edge; return at the next falling edge,
  // where registered outputs reflect that cycle
  task automatic cyc(input logic [31:0] a, input logic [31:0] d, input logic we, input logic [3:0] be);
    bus_addr = a; bus_wdata = d; bus_we = we; bus_be = be;
    @(negedge clk);
    bus_we = 1'b0; bus_be = '0;
  endtask

  task automatic store(input logic [31:0] d);
    cyc(SA, d, 1'b1, 4'hF);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [31:0] dump_val(input int i, input int seed);
    return (32'(i) * 32'h0101_0101) ^ (32'(seed) << 20) ^ 32'h0000_0003;
  endfunction

  task automatic run_dump(input int seed, input bit noise);
    store(32'h0000_0002);
    pulses(4'b0000, "R5 dump header no pulse");
    for (int i = 0; i < 32; i++) begin
      if (noise && (i % 7 == 3)) begin
        cyc(SA, 32'h0000_0001, 1'b1, 4'h7);
        pulses(4'b0000, "R2 partial strobe in burst");
        cyc(SA + 4, 32'h0000_0000, 1'b1, 4'hF);
        pulses(4'b0000, "R2 other address in burst");
      end
      store(dump_val(i, seed));
      pulses(4'b0010, "R5/R6 dump pulse");
      chk(gpr_idx === 5'(i), "R5 index", 64'(gpr_idx), 64'(i));
      chk(gpr_data === dump_val(i, seed), "R5/R6 data", 64'(gpr_data), 64'(dump_val(i, seed)));
      chk(gpr_done === 1'b0, "R7 no early done", 64'(gpr_done), 64'd0);
    end
    cyc('0, '0, 1'b0, '0);
    chk(gpr_done === 1'b1, "R7 done after last", 64'(gpr_done), 64'd1);
    pulses(4'b0000, "R7 no valid with done");
    cyc('0, '0, 1'b0, '0);
    chk(gpr_done === 1'b0, "R7 done one cycle", 64'(gpr_done), 64'd0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    pulses(4'b0000, "R1 reset pulses");
    chk(proto_err === 1'b0 && gpr_done === 1'b0, "R1 reset flags", 64'({proto_err, gpr_done}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: non-store cycles with a valid-looking header
    cyc(SA, 32'h0000_0500, 1'b0, 4'hF);
    pulses(4'b0000, "R2 we low");
    for (int b = 0; b < 15; b++) begin
      cyc(SA, 32'h0000_0500, 1'b1, 4'(b));
      pulses(4'b0000, "R2 partial strobe");
    end
    cyc(32'h8FFF_FFF8, 32'h0000_0500, 1'b1, 4'hF);
    pulses(4'b0000, "R2 other address");

    // R3 status sweep
    for (int k = 0; k < 24; k++) begin
      logic [23:0] v;
      v = 24'(1) << k ^ 24'(k);
      store({v, 8'h00});
      pulses(4'b1000, "R3 status pulse");
      chk(status_code === v, "R3 status code", 64'(status_code), 64'(v));
      cyc('0, '0, 1'b0, '0);
      pulses(4'b0000, "R3 single cycle");
    end
    // R4 verdicts, back-to-back
    for (int k = 0; k < 4; k++) begin
      store({24'(k * 3), 8'h01});
      pulses(4'b0100, "R4 result pulse");
      chk(result_code === 24'(k * 3), "R4 result code", 64'(result_code), 64'(k * 3));
    end

    run_dump(1, 1'b0);
    run_dump(5, 1'b1);

    // R8 control-register pairs; R6 with data that looks like headers
    for (int k = 0; k < 6; k++) begin
      logic [11:0] ca;
      logic [31:0] cv;
      ca = 12'h300 + 12'(k * 37);
      cv = 32'(k) | 32'hC0DE_0000;
      store({12'hABC, ca, 8'h03});
      pulses(4'b0000, "R8 header no pulse");
      cyc(SA, 32'h0000_0002, 1'b1, 4'hE);
      pulses(4'b0000, "R2 partial in pair");
      store(cv);
      pulses(4'b0001, "R8/R6 pair pulse");
      chk(csr_addr === ca, "R8 address", 64'(csr_addr), 64'(ca));
      chk(csr_data === cv, "R8 value", 64'(csr_data), 64'(cv));
    end
    store(32'h0000_0304 << 8 | 32'h3);
    store(32'h0000_0002);
    pulses(4'b0001, "R6 kind-like data in pair");
    chk(csr_addr === 12'h304, "R8 example addr", 64'(csr_addr), 64'h304);
    store(32'h0000_0700);
    pulses(4'b1000, "R6 decoder idle again");

    // R9 unknown kinds
    chk(proto_err === 1'b0, "R9 clean before", 64'(proto_err), 64'd0);
    for (int t = 4; t < 256; t++) begin
      store({24'hFFFFFF, 8'(t)});
      pulses(4'b0000, "R9 unknown no pulse");
      chk(proto_err === 1'b1, "R9 error set", 64'(proto_err), 64'd1);
    end
    store(32'h0000_0201);
    pulses(4'b0100, "R9 still idle after unknown");
    chk(proto_err === 1'b1, "R9 sticky", 64'(proto_err), 64'd1);
    do_reset();
    chk(proto_err === 1'b0, "R9/R1 cleared by reset", 64'(proto_err), 64'd0);

    // R2: a pending burst survives ignored cycles
    store(32'h0000_0003 | (32'h123 << 8));
    for (int b = 0; b < 4; b++) begin
      cyc(SA ^ (32'h4 << b), 32'h1, 1'b1, 4'hF);
      pulses(4'b0000, "R2 off address while pending");
    end
    store(32'h5555_AAAA);
    pulses(4'b0001, "R2 pending kept");
    chk(csr_data === 32'h5555_AAAA, "R8 after noise", 64'(csr_data), 64'h5555_AAAA);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule